// File: doc/BRIEF.md
# Character Cursor Address Counter

This block keeps the single address counter that a character display controller shares between its text memory and its glyph memory, and applies the cursor rules to it. The decoder in front of it turns host commands into one-cycle strobes. The block answers each strobe with a new address, a flag that tells which memory the address points into, and pulses that ask the display pipeline to scroll the whole picture or to undo any scroll.

Text memory is not one flat range. Every text line owns a fixed window, and the top address bits pick the line. In two-line mode, bit 7 is the line and bits 6:0 are the column, with 80 columns. In four-line mode, bits 7:6 are the line and bits 5:0 are the column, with 40 columns. Stepping past the end of a window lands in the next line's window. Vertical moves change only the line bits.

Glyph memory uses a 5-bit address. It steps modulo 32 and never wraps between line windows. Every strobe takes effect at the clock edge that samples it, so its result is visible in the following cycle. All control and status pins are plain level or pulse signals, because this block carries no data stream.

Top module: `cursor_addr_ctr`

## Requirements
- R1: After reset, `addr` is 0x00, `cg_sel` is 0, the step direction is forward, the scroll option is off, and `shift_req`, `shift_left` and `shift_clr` are 0.
- R2: In two-line mode, an access in text mode steps the address by +1 (forward) or −1 (backward) within the window. Forward from 0x4F gives 0x80 and from 0xCF gives 0x00. Backward from 0x80 gives 0x4F and from 0x00 gives 0xCF.
- R3: In four-line mode, an access in text mode steps within the windows 0x00–0x27, 0x40–0x67, 0x80–0xA7 and 0xC0–0xE7. Forward from the last column enters column 0 of the next line, and 0xE7 goes to 0x00. Backward from column 0 enters the last column of the previous line, and 0x00 goes to 0xE7.
- R4: `cmd_home` sets `addr` to 0x00 and `cg_sel` to 0, and pulses `shift_clr` for one cycle.
- R5: `cmd_cret` clears the column bits, keeps the line bits (bit 7 in two-line mode, bits 7:6 in four-line mode) and sets `cg_sel` to 0.
- R6: A write access (`access_write`=1) in text mode with the scroll option on pulses `shift_req` for one cycle. `shift_left` is 1 when the direction is forward and 0 when it is backward. Reads, glyph-mode accesses and writes with the option off leave `shift_req` and `shift_left` at 0.
- R7: `cmd_cg_load` sets `addr` to {000, `load_addr`[4:0]} and `cg_sel` to 1. In glyph mode, accesses and left/right moves step the low 5 bits modulo 32, up/down moves leave `addr` unchanged, and `addr`[7:5] stays 0.
- R8: `cmd_dd_load` sets `addr` to the full 8-bit `load_addr` and `cg_sel` to 0.
- R9: `cmd_move` with `move_dir`=00 (left) or 01 (right) steps the text address backward or forward by the window rules of R2/R3 and never requests a scroll.
- R10: `cmd_move` with `move_dir`=10 (up) or 11 (down) moves one line up or down and keeps the column. Up from the first line goes to the last line, and down from the last line goes to the first.
- R11: `cmd_clear` sets `addr` to 0x00, sets `cg_sel` to 0, sets the direction to forward, keeps the scroll option, and pulses `shift_clr`.
- R12: `cmd_entry` leaves the address unchanged. It loads the direction from `entry_inc` (1 = forward) and the scroll option from `entry_shift`, and later accesses use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| four_line | input | 1 | 1 = four-line windows, 0 = two-line windows |
| cmd_clear | input | 1 | Clear strobe |
| cmd_home | input | 1 | Cursor-home strobe |
| cmd_cret | input | 1 | Carriage-return strobe |
| cmd_entry | input | 1 | Entry-mode strobe |
| entry_inc | input | 1 | Direction for `cmd_entry` (1 = forward) |
| entry_shift | input | 1 | Scroll option for `cmd_entry` |
| cmd_move | input | 1 | Cursor-move strobe |
| move_dir | input | 2 | 00 left, 01 right, 10 up, 11 down |
| cmd_dd_load | input | 1 | Load a text address |
| cmd_cg_load | input | 1 | Load a glyph address |
| load_addr | input | 8 | Address for the load strobes |
| access_pulse | input | 1 | One memory access has completed |
| access_write | input | 1 | 1 = the access was a write |
| addr | output | 8 | Current address |
| cg_sel | output | 1 | 1 = glyph memory, 0 = text memory |
| shift_req | output | 1 | Scroll request pulse |
| shift_left | output | 1 | Scroll direction (1 = left) while `shift_req` is 1 |
| shift_clr | output | 1 | Pulse that cancels any scroll |

## Verification
The assertions assume the decoder raises at most one strobe per cycle. One of them checks this, and the stimulus drives exactly one strobe or none in each cycle. They also assume that text addresses are loaded only inside a line window, and that `four_line` changes only in the same cycle as a load or clear. The stimulus picks load addresses from a valid line and column and changes the line mode only together with a load, so no hole address is ever reached.

// File: rtl/cac_pkg.sv
package cac_pkg;
  // Encoding shared with move_dir: 00 back, 01 forward, 10 up, 11 down
  typedef enum logic [1:0] {
    STEP_BACK = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_UP   = 2'd2,
    STEP_DOWN = 2'd3
  } step_op_e;
endpackage

// File: rtl/cac_line_step.sv
module cac_line_step
  import cac_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int COLS_TWO  = 80,
  parameter int COLS_FOUR = 40
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              four_line,
  input  step_op_e          op,
  output logic [ADDR_W-1:0] nxt
);
  localparam int COL_W = ADDR_W - 1;
  localparam logic [COL_W-1:0] LAST_TWO  = COL_W'(COLS_TWO - 1);
  localparam logic [COL_W-1:0] LAST_FOUR = COL_W'(COLS_FOUR - 1);

  logic [1:0]       line, line_n;
  logic [COL_W-1:0] col, col_n, last;

  always_comb begin
    if (four_line) begin
      line = cur[ADDR_W-1 -: 2];
      col  = {1'b0, cur[ADDR_W-3:0]};
      last = LAST_FOUR;
    end else begin
      line = {1'b0, cur[ADDR_W-1]};
      col  = cur[COL_W-1:0];
      last = LAST_TWO;
    end
    line_n = line;
    col_n  = col;
    unique case (op)
      STEP_FWD: begin
        if (col >= last) begin
          col_n  = '0;
          line_n = line + 2'd1;
        end else begin
          col_n = col + 1'b1;
        end
      end
      STEP_BACK: begin
        if (col == '0) begin
          col_n  = last;
          line_n = line - 2'd1;
        end else begin
          col_n = col - 1'b1;
        end
      end
      STEP_UP:   line_n = line - 2'd1;
      STEP_DOWN: line_n = line + 2'd1;
      default:   line_n = line;
    endcase
    if (four_line) nxt = {line_n, col_n[ADDR_W-3:0]};
    else           nxt = {line_n[0], col_n};
  end
endmodule

// File: rtl/cac_entry_reg.sv
module cac_entry_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_clear,
  input  logic cmd_entry,
  input  logic entry_inc,
  input  logic entry_shift,
  output logic inc_q,
  output logic shift_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q   <= 1'b1;
      shift_q <= 1'b0;
    end else if (cmd_clear) begin
      inc_q <= 1'b1;
    end else if (cmd_entry) begin
      inc_q   <= entry_inc;
      shift_q <= entry_shift;
    end
  end
endmodule

// File: rtl/cac_shift_gen.sv
module cac_shift_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic text_write,
  input  logic shift_opt,
  input  logic inc,
  input  logic cancel,
  output logic shift_req,
  output logic shift_left,
  output logic shift_clr
);
  logic fire;
  assign fire = text_write & shift_opt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_req  <= 1'b0;
      shift_left <= 1'b0;
      shift_clr  <= 1'b0;
    end else begin
      shift_req  <= fire;
      shift_left <= fire & inc;
      shift_clr  <= cancel;
    end
  end

  // R6: without the scroll option no request may follow
  a_r6_opt_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_opt |=> !shift_req);
endmodule

// File: rtl/cursor_addr_ctr.sv
module cursor_addr_ctr
  import cac_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CG_W      = 5,
  parameter int COLS_TWO  = 80,
  parameter int COLS_FOUR = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              four_line,
  input  logic              cmd_clear,
  input  logic              cmd_home,
  input  logic              cmd_cret,
  input  logic              cmd_entry,
  input  logic              entry_inc,
  input  logic              entry_shift,
  input  logic              cmd_move,
  input  logic [1:0]        move_dir,
  input  logic              cmd_dd_load,
  input  logic              cmd_cg_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              access_pulse,
  input  logic              access_write,
  output logic [ADDR_W-1:0] addr,
  output logic              cg_sel,
  output logic              shift_req,
  output logic              shift_left,
  output logic              shift_clr
);
  localparam int HI_W = ADDR_W - CG_W;
  localparam logic [ADDR_W-1:0] MASK_TWO  = {1'b1,  {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] MASK_FOUR = {2'b11, {(ADDR_W-2){1'b0}}};

  logic [ADDR_W-1:0] addr_q, addr_d, win_nxt;
  logic              cg_q, cg_d;
  logic              inc_q, shift_opt_q;
  logic              other_cmd, access_eff, cg_fwd;
  logic [CG_W-1:0]   cg_low_n;
  step_op_e          op;

  assign other_cmd  = cmd_clear | cmd_home | cmd_cret | cmd_entry |
                      cmd_move | cmd_dd_load | cmd_cg_load;
  assign access_eff = access_pulse & ~other_cmd;
  assign op         = cmd_move ? step_op_e'(move_dir)
                               : (inc_q ? STEP_FWD : STEP_BACK);
  assign cg_fwd     = cmd_move ? move_dir[0] : inc_q;
  assign cg_low_n   = cg_fwd ? addr_q[CG_W-1:0] + 1'b1
                             : addr_q[CG_W-1:0] - 1'b1;

  cac_line_step #(
    .ADDR_W(ADDR_W), .COLS_TWO(COLS_TWO), .COLS_FOUR(COLS_FOUR)
  ) u_step (
    .cur(addr_q), .four_line(four_line), .op(op), .nxt(win_nxt)
  );

  cac_entry_reg u_entry (
    .clk(clk), .rst_n(rst_n), .cmd_clear(cmd_clear), .cmd_entry(cmd_entry),
    .entry_inc(entry_inc), .entry_shift(entry_shift),
    .inc_q(inc_q), .shift_q(shift_opt_q)
  );

  cac_shift_gen u_shift (
    .clk(clk), .rst_n(rst_n),
    .text_write(access_eff & access_write & ~cg_q),
    .shift_opt(shift_opt_q), .inc(inc_q),
    .cancel(cmd_clear | cmd_home),
    .shift_req(shift_req), .shift_left(shift_left), .shift_clr(shift_clr)
  );

  always_comb begin
    addr_d = addr_q;
    cg_d   = cg_q;
    if (cmd_clear || cmd_home) begin
      addr_d = '0;
      cg_d   = 1'b0;
    end else if (cmd_cret) begin
      addr_d = addr_q & (four_line ? MASK_FOUR : MASK_TWO);
      cg_d   = 1'b0;
    end else if (cmd_dd_load) begin
      addr_d = load_addr;
      cg_d   = 1'b0;
    end else if (cmd_cg_load) begin
      addr_d = {{HI_W{1'b0}}, load_addr[CG_W-1:0]};
      cg_d   = 1'b1;
    end else if (cmd_move) begin
      if (!cg_q)             addr_d = win_nxt;
      else if (!move_dir[1]) addr_d = {{HI_W{1'b0}}, cg_low_n};
    end else if (access_eff) begin
      addr_d = cg_q ? {{HI_W{1'b0}}, cg_low_n} : win_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cg_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      cg_q   <= cg_d;
    end
  end

  assign addr   = addr_q;
  assign cg_sel = cg_q;

  // Input contract: the decoder raises at most one strobe per cycle
  a_in_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_clear, cmd_home, cmd_cret, cmd_entry, cmd_move,
              cmd_dd_load, cmd_cg_load, access_pulse}));

  a_r4_home: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_home |=> (addr == '0) && !cg_sel && shift_clr);

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> (addr == '0) && !cg_sel && shift_clr);

  a_r8_text_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dd_load |=> (addr == $past(load_addr)) && !cg_sel);

  a_r7_glyph_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cg_sel |-> (addr[ADDR_W-1:CG_W] == '0));

  a_r5_cret_two: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cret && !four_line) |=>
      (addr[ADDR_W-2:0] == '0) && (addr[ADDR_W-1] == $past(addr[ADDR_W-1])) && !cg_sel);

  a_r5_cret_four: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cret && four_line) |=>
      (addr[ADDR_W-3:0] == '0) && (addr[ADDR_W-1 -: 2] == $past(addr[ADDR_W-1 -: 2])) && !cg_sel);

  a_r6_read_no_scroll: assert property (@(posedge clk) disable iff (!rst_n)
    (access_pulse && !access_write) |=> !shift_req);

  a_r9_move_no_scroll: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_move |=> !shift_req);

  a_r10_column_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_move && move_dir[1] && !cg_sel && four_line) |=>
      (addr[ADDR_W-3:0] == $past(addr[ADDR_W-3:0])));
endmodule

// File: tb/cursor_addr_ctr_test.sv
`timescale 1ns/1ps
module cursor_addr_ctr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic four_line = 1'b0;
  logic cmd_clear = 0, cmd_home = 0, cmd_cret = 0, cmd_entry = 0;
  logic entry_inc = 0, entry_shift = 0, cmd_move = 0;
  logic [1:0] move_dir = 2'b00;
  logic cmd_dd_load = 0, cmd_cg_load = 0;
  logic [7:0] load_addr = 8'h00;
  logic access_pulse = 0, access_write = 0;
  logic [7:0] addr;
  logic cg_sel, shift_req, shift_left, shift_clr;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  cursor_addr_ctr uut (
    .clk(clk), .rst_n(rst_n), .four_line(four_line),
    .cmd_clear(cmd_clear), .cmd_home(cmd_home), .cmd_cret(cmd_cret),
    .cmd_entry(cmd_entry), .entry_inc(entry_inc), .entry_shift(entry_shift),
    .cmd_move(cmd_move), .move_dir(move_dir), .cmd_dd_load(cmd_dd_load),
    .cmd_cg_load(cmd_cg_load), .load_addr(load_addr),
    .access_pulse(access_pulse), .access_write(access_write),
    .addr(addr), .cg_sel(cg_sel), .shift_req(shift_req),
    .shift_left(shift_left), .shift_clr(shift_clr)
  );

  // ---------- behavioural reference ----------
  int m_addr = 0;
  bit m_cg = 0, m_inc = 1, m_shift = 0, m_req = 0, m_left = 0, m_clr = 0;

  function automatic int win_step(int a, bit four, int kind);
    int nl   = four ? 4 : 2;
    int cols = four ? 40 : 80;
    int sh   = four ? 6 : 7;
    int ln   = a >> sh;
    int cl   = a & ((1 << sh) - 1);
    case (kind)
      1: if (cl >= cols - 1) begin cl = 0; ln = (ln + 1) % nl; end else cl = cl + 1;
      0: if (cl == 0) begin cl = cols - 1; ln = (ln + nl - 1) % nl; end else cl = cl - 1;
      2: ln = (ln + nl - 1) % nl;
      default: ln = (ln + 1) % nl;
    endcase
    return (ln << sh) | cl;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_cg = 0; m_inc = 1; m_shift = 0;
      m_req = 0; m_left = 0; m_clr = 0;
    end else begin
      m_req  = access_pulse && access_write && !m_cg && m_shift;
      m_left = m_req && m_inc;
      m_clr  = cmd_clear || cmd_home;
      if (cmd_clear || cmd_home) begin
        m_addr = 0; m_cg = 0;
        if (cmd_clear) m_inc = 1;
      end else if (cmd_cret) begin
        m_addr = m_addr & (four_line ? 'hC0 : 'h80); m_cg = 0;
      end else if (cmd_entry) begin
        m_inc = entry_inc; m_shift = entry_shift;
      end else if (cmd_dd_load) begin
        m_addr = int'(load_addr); m_cg = 0;
      end else if (cmd_cg_load) begin
        m_addr = int'(load_addr) % 32; m_cg = 1;
      end else if (cmd_move) begin
        if (!m_cg) m_addr = win_step(m_addr, four_line, int'(move_dir));
        else if (move_dir == 2'b01) m_addr = (m_addr + 1) % 32;
        else if (move_dir == 2'b00) m_addr = (m_addr + 31) % 32;
      end else if (access_pulse) begin
        if (m_cg) m_addr = m_inc ? (m_addr + 1) % 32 : (m_addr + 31) % 32;
        else      m_addr = win_step(m_addr, four_line, m_inc ? 1 : 0);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    checks++;
    if (int'(addr) != m_addr || cg_sel != m_cg || shift_req != m_req ||
        shift_left != m_left || shift_clr != m_clr) begin
      errors++;
      $display("FAIL %s: addr=%02h cg=%0b req=%0b left=%0b clr=%0b expected addr=%02h cg=%0b req=%0b left=%0b clr=%0b",
               cur_req, addr, cg_sel, shift_req, shift_left, shift_clr,
               m_addr, m_cg, m_req, m_left, m_clr);
    end
  end

  // ---------- stimulus helpers ----------
  // kinds: 0 idle, 1 clear, 2 home, 3 cret, 4 entry, 5 move, 6 text load,
  //        7 glyph load, 8 access
  task automatic issue(input int kind, input logic [7:0] a, input bit b,
                       input bit c, input string req);
    @(negedge clk);
    cur_req = req;
    cmd_clear = 0; cmd_home = 0; cmd_cret = 0; cmd_entry = 0; cmd_move = 0;
    cmd_dd_load = 0; cmd_cg_load = 0; access_pulse = 0;
    case (kind)
      1: cmd_clear = 1;
      2: cmd_home = 1;
      3: cmd_cret = 1;
      4: begin cmd_entry = 1; entry_inc = b; entry_shift = c; end
      5: begin cmd_move = 1; move_dir = a[1:0]; end
      6: begin cmd_dd_load = 1; load_addr = a; end
      7: begin cmd_cg_load = 1; load_addr = a; end
      8: begin access_pulse = 1; access_write = b; end
      default: ;
    endcase
  endtask

  task automatic expect_out(input logic [7:0] ea, input bit ecg, input bit ereq,
                            input bit eleft, input string req);
    @(posedge clk);
    #1.5;
    checks++;
    if (addr != ea || cg_sel != ecg || shift_req != ereq || shift_left != eleft) begin
      errors++;
      $display("FAIL %s: addr=%02h cg=%0b req=%0b left=%0b expected addr=%02h cg=%0b req=%0b left=%0b",
               req, addr, cg_sel, shift_req, shift_left, ea, ecg, ereq, eleft);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    issue(0, 0, 0, 0, "R1"); expect_out(8'h00, 0, 0, 0, "R1");

    // two-line windows
    issue(6, 8'h4E, 0, 0, "R8"); expect_out(8'h4E, 0, 0, 0, "R8");
    issue(8, 0, 1, 0, "R2");     expect_out(8'h4F, 0, 0, 0, "R2");
    issue(8, 0, 1, 0, "R2");     expect_out(8'h80, 0, 0, 0, "R2");
    issue(6, 8'hCF, 0, 0, "R8"); expect_out(8'hCF, 0, 0, 0, "R8");
    issue(8, 0, 0, 0, "R2");     expect_out(8'h00, 0, 0, 0, "R2");
    issue(4, 0, 0, 0, "R12");    expect_out(8'h00, 0, 0, 0, "R12");
    issue(8, 0, 0, 0, "R2");     expect_out(8'hCF, 0, 0, 0, "R2");
    issue(6, 8'h80, 0, 0, "R8"); expect_out(8'h80, 0, 0, 0, "R8");
    issue(8, 0, 1, 0, "R2");     expect_out(8'h4F, 0, 0, 0, "R2");

    // scroll requests
    issue(4, 0, 1, 1, "R12");    expect_out(8'h4F, 0, 0, 0, "R12");
    issue(8, 0, 1, 0, "R6");     expect_out(8'h80, 0, 1, 1, "R6");
    issue(8, 0, 0, 0, "R6");     expect_out(8'h81, 0, 0, 0, "R6");
    issue(4, 0, 0, 1, "R12");    expect_out(8'h81, 0, 0, 0, "R12");
    issue(8, 0, 1, 0, "R6");     expect_out(8'h80, 0, 1, 0, "R6");
    issue(5, 8'h01, 0, 0, "R9"); expect_out(8'h81, 0, 0, 0, "R9");

    // glyph memory
    issue(7, 8'hFF, 0, 0, "R7"); expect_out(8'h1F, 1, 0, 0, "R7");
    issue(8, 0, 1, 0, "R7");     expect_out(8'h1E, 1, 0, 0, "R7");
    issue(4, 0, 1, 1, "R12");    expect_out(8'h1E, 1, 0, 0, "R12");
    issue(8, 0, 1, 0, "R7");     expect_out(8'h1F, 1, 0, 0, "R7");
    issue(8, 0, 1, 0, "R7");     expect_out(8'h00, 1, 0, 0, "R7");
    issue(5, 8'h00, 0, 0, "R7"); expect_out(8'h1F, 1, 0, 0, "R7");
    issue(5, 8'h02, 0, 0, "R7"); expect_out(8'h1F, 1, 0, 0, "R7");

    // carriage return, moves, home, clear
    issue(6, 8'hC5, 0, 0, "R8"); expect_out(8'hC5, 0, 0, 0, "R8");
    issue(3, 0, 0, 0, "R5");     expect_out(8'h80, 0, 0, 0, "R5");
    issue(6, 8'h85, 0, 0, "R8"); expect_out(8'h85, 0, 0, 0, "R8");
    issue(5, 8'h02, 0, 0, "R10"); expect_out(8'h05, 0, 0, 0, "R10");
    issue(5, 8'h02, 0, 0, "R10"); expect_out(8'h85, 0, 0, 0, "R10");
    issue(5, 8'h03, 0, 0, "R10"); expect_out(8'h05, 0, 0, 0, "R10");
    issue(6, 8'h00, 0, 0, "R8"); expect_out(8'h00, 0, 0, 0, "R8");
    issue(5, 8'h00, 0, 0, "R9"); expect_out(8'hCF, 0, 0, 0, "R9");
    issue(5, 8'h01, 0, 0, "R9"); expect_out(8'h00, 0, 0, 0, "R9");
    issue(6, 8'h47, 0, 0, "R8"); expect_out(8'h47, 0, 0, 0, "R8");
    issue(2, 0, 0, 0, "R4");     expect_out(8'h00, 0, 0, 0, "R4");
    issue(4, 0, 0, 1, "R12");    expect_out(8'h00, 0, 0, 0, "R12");
    issue(6, 8'h33, 0, 0, "R8"); expect_out(8'h33, 0, 0, 0, "R8");
    issue(1, 0, 0, 0, "R11");    expect_out(8'h00, 0, 0, 0, "R11");
    issue(8, 0, 1, 0, "R11");    expect_out(8'h01, 0, 1, 1, "R11");

    // four-line windows
    @(negedge clk); four_line = 1;
    issue(6, 8'h27, 0, 0, "R3"); expect_out(8'h27, 0, 0, 0, "R3");
    issue(4, 0, 1, 0, "R12");    expect_out(8'h27, 0, 0, 0, "R12");
    issue(8, 0, 0, 0, "R3");     expect_out(8'h40, 0, 0, 0, "R3");
    issue(6, 8'h67, 0, 0, "R3"); expect_out(8'h67, 0, 0, 0, "R3");
    issue(8, 0, 0, 0, "R3");     expect_out(8'h80, 0, 0, 0, "R3");
    issue(6, 8'hA7, 0, 0, "R3"); expect_out(8'hA7, 0, 0, 0, "R3");
    issue(8, 0, 0, 0, "R3");     expect_out(8'hC0, 0, 0, 0, "R3");
    issue(6, 8'hE7, 0, 0, "R3"); expect_out(8'hE7, 0, 0, 0, "R3");
    issue(8, 0, 0, 0, "R3");     expect_out(8'h00, 0, 0, 0, "R3");
    issue(4, 0, 0, 0, "R12");    expect_out(8'h00, 0, 0, 0, "R12");
    issue(8, 0, 0, 0, "R3");     expect_out(8'hE7, 0, 0, 0, "R3");
    issue(6, 8'h40, 0, 0, "R3"); expect_out(8'h40, 0, 0, 0, "R3");
    issue(8, 0, 0, 0, "R3");     expect_out(8'h27, 0, 0, 0, "R3");
    issue(6, 8'h45, 0, 0, "R10"); expect_out(8'h45, 0, 0, 0, "R10");
    issue(5, 8'h02, 0, 0, "R10"); expect_out(8'h05, 0, 0, 0, "R10");
    issue(5, 8'h02, 0, 0, "R10"); expect_out(8'hC5, 0, 0, 0, "R10");
    issue(5, 8'h03, 0, 0, "R10"); expect_out(8'h05, 0, 0, 0, "R10");
    issue(6, 8'hA3, 0, 0, "R5"); expect_out(8'hA3, 0, 0, 0, "R5");
    issue(3, 0, 0, 0, "R5");     expect_out(8'h80, 0, 0, 0, "R5");

    // mixed traffic compared cycle by cycle against the reference
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 10);
      bit fl = four_line;
      if (k == 9) fl = ~four_line;
      if (k >= 9) begin
        int nl = fl ? 4 : 2;
        int cols = fl ? 40 : 80;
        int ln = $urandom_range(0, nl - 1);
        int cl = $urandom_range(0, cols - 1);
        int a = fl ? (ln * 64 + cl) : (ln * 128 + cl);
        @(negedge clk); four_line = fl;
        cmd_dd_load = 1; load_addr = 8'(a); cur_req = "R8";
        cmd_clear = 0; cmd_home = 0; cmd_cret = 0; cmd_entry = 0;
        cmd_move = 0; cmd_cg_load = 0; access_pulse = 0;
      end else if (k == 8 || k == 6) begin
        issue(8, 0, bit'($urandom_range(0, 1)), 0, four_line ? "R3" : "R2");
      end else begin
        issue(k, 8'($urandom_range(0, 255)), bit'($urandom_range(0, 1)),
              bit'($urandom_range(0, 1)), "R9");
      end
    end
    issue(0, 0, 0, 0, "R12");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule